// File: doc/BRIEF.md
# Timer Channel Compare Reference Generator

This block builds the internal reference level for one channel of a general-purpose timer. On every clock it compares the timer's counter value with a programmable compare value. A 3-bit mode code then decides how the reference level moves. The available behaviours are: hold the level, set it on a match, clear it on a match, toggle it on a match, force it low, force it high, and two pulse-width modulation shapes that depend on the count direction.

A separate clear path can pull the reference to 0 from an external signal, but only while a clear-enable bit is set. Once the reference has been cleared this way, it stays at 0 until the next update event of the counter, even if a later compare match would otherwise restore it. The block also gives a one-cycle strobe whenever counter and compare are equal.

Polarity, dead-time, the counter itself and capture logic live in neighbouring blocks.

Top module: `ocref_gen`

## Requirements
- R1: After reset, `ref_out` and `match_pulse` are both 0.
- R2: Mode 0 (freeze) keeps `ref_out` at its current level, whatever the compare result is.
- R3: Mode 1 drives the level to 1 on a match and mode 2 drives it to 0 on a match. Without a match, both modes leave the level unchanged.
- R4: Mode 3 inverts the level on every cycle in which counter equals compare, and leaves it unchanged on all other cycles.
- R5: Mode 4 forces the level to 0 and mode 5 forces it to 1, regardless of the compare result.
- R6: Mode 6 (PWM 0) works as follows. When counting up (`cnt_down`=0), the level is 1 exactly while counter < compare. When counting down, the level is 0 exactly while counter > compare.
- R7: Mode 7 (PWM 1) gives the bitwise inverse of the mode 6 level for the same inputs.
- R8: A compare value of 0 holds mode 6 at 0 and mode 7 at 1 in both directions. A compare value above every counter value reached holds mode 6 at 1.
- R9: When `clr_en`=1 and `ext_clr`=1 at a clock edge, `ref_out` is 0 after that edge. When `clr_en`=0, `ext_clr` has no effect.
- R10: After an external clear, `ref_out` stays 0 until an edge at which `upd_evt`=1 and `ext_clr`=0. After that edge, the level set by the mode appears again.
- R11: `match_pulse` is 1 in the cycle after a clock edge at which counter equals compare, and 0 otherwise.
- R12: Inputs sampled at a clock edge take effect on `ref_out` right after that edge, not before it. This applies to mode changes as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| upd_evt | input | 1 | Update-event strobe from the counter |
| cmp_val | input | CNT_W | Compare value |
| mode | input | 3 | Reference mode code (0 to 7) |
| clr_en | input | 1 | Enables the external clear |
| ext_clr | input | 1 | External clear request |
| ref_out | output | 1 | Reference level |
| match_pulse | output | 1 | Counter-equals-compare strobe |

## Verification
The bench goes after four corner cases.

- **Compare value of 0 while counting down.** A plain `counter > compare` test lets the level rise at count 0. A design without the zero guard would emit a one-cycle glitch where a flat line is expected.
- **Release of the clear latch.** A design that releases the latch on a compare match, or on an update event while `ext_clr` is still high, brings the reference back too early.
- **Toggle on consecutive matches and freeze after a forced level.** These expose a level that is re-computed instead of held.
- **`ext_clr` with `clr_en` low.** This catches a clear that is not gated by the enable.

// File: rtl/ocref_gen.sv
module ocref_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       mode,
  input  logic             clr_en,
  input  logic             ext_clr,
  output logic             ref_out,
  output logic             match_pulse
);

  localparam logic [2:0] M_FREEZE = 3'd0;
  localparam logic [2:0] M_SET    = 3'd1;
  localparam logic [2:0] M_CLR    = 3'd2;
  localparam logic [2:0] M_TOG    = 3'd3;
  localparam logic [2:0] M_LOW    = 3'd4;
  localparam logic [2:0] M_HIGH   = 3'd5;
  localparam logic [2:0] M_PWM0   = 3'd6;
  localparam logic [2:0] M_PWM1   = 3'd7;

  logic base_q, base_d, hold_q, match_q;
  logic eq, lt, gt, pwm0_lvl, clr_req;

  assign eq      = (cnt_val == cmp_val);
  assign lt      = (cnt_val <  cmp_val);
  assign gt      = (cnt_val >  cmp_val);
  assign clr_req = clr_en & ext_clr;

  assign pwm0_lvl = (cmp_val == '0) ? 1'b0 : (cnt_down ? ~gt : lt);

  always_comb begin
    base_d = base_q;
    case (mode)
      M_FREEZE: base_d = base_q;
      M_SET:    if (eq) base_d = 1'b1;
      M_CLR:    if (eq) base_d = 1'b0;
      M_TOG:    if (eq) base_d = ~base_q;
      M_LOW:    base_d = 1'b0;
      M_HIGH:   base_d = 1'b1;
      M_PWM0:   base_d = pwm0_lvl;
      M_PWM1:   base_d = ~pwm0_lvl;
      default:  base_d = base_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= 1'b0;
      hold_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      base_q  <= base_d;
      match_q <= eq;
      if (clr_req)
        hold_q <= 1'b1;
      else if (upd_evt && !ext_clr)
        hold_q <= 1'b0;
    end
  end

  assign ref_out     = base_q & ~hold_q;
  assign match_pulse = match_q;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!ref_out && !match_pulse));

  p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FREEZE) |=> $stable(base_q));

  p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SET && eq && !hold_q && !clr_req) |=> ref_out);

  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOW) |=> !ref_out);

  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HIGH && !hold_q && !clr_req) |=> ref_out);

  p_ext_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !ref_out);

  p_clear_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !(upd_evt && !ext_clr)) |=> !ref_out);

  p_match_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eq |=> match_pulse);

  p_no_false_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eq |=> !match_pulse);

endmodule

// File: tb/tb_ocref_gen.sv
module tb_ocref_gen;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0, cmp_val = '0;
  logic cnt_down = 1'b0, upd_evt = 1'b0, clr_en = 1'b0, ext_clr = 1'b0;
  logic [2:0] mode = 3'd0;
  logic ref_out, match_pulse;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ocref_gen #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .upd_evt(upd_evt), .cmp_val(cmp_val), .mode(mode), .clr_en(clr_en),
    .ext_clr(ext_clr), .ref_out(ref_out), .match_pulse(match_pulse));

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [2:0] m, input int c, input int k);
    mode = m; cnt_val = W'(c); cmp_val = W'(k); cyc();
  endtask

  task automatic t_reset();
    chk("R1 ref", ref_out, 1'b0);
    chk("R1 match", match_pulse, 1'b0);
  endtask

  task automatic t_forced();
    drive(3'd4, 7, 7); chk("R5 low on match", ref_out, 1'b0);
    mode = 3'd5; cnt_val = 16'd1; cmp_val = 16'd9;
    chk("R12 before edge", ref_out, 1'b0);
    cyc(); chk("R12 after edge / R5 high", ref_out, 1'b1);
    drive(3'd5, 9, 9); chk("R5 high on match", ref_out, 1'b1);
  endtask

  task automatic t_freeze();
    drive(3'd5, 0, 3);
    for (int i = 0; i < 5; i++) begin
      drive(3'd0, i, 3); chk("R2 freeze high", ref_out, 1'b1);
    end
    drive(3'd4, 0, 3);
    drive(3'd0, 3, 3); chk("R2 freeze low on match", ref_out, 1'b0);
  endtask

  task automatic t_setclr();
    drive(3'd4, 0, 5);
    drive(3'd1, 2, 5); chk("R3 set no match", ref_out, 1'b0);
    chk("R11 no strobe", match_pulse, 1'b0);
    drive(3'd1, 5, 5); chk("R3 set on match", ref_out, 1'b1);
    chk("R11 strobe", match_pulse, 1'b1);
    drive(3'd2, 6, 5); chk("R3 clr no match", ref_out, 1'b1);
    chk("R11 strobe ends", match_pulse, 1'b0);
    drive(3'd2, 5, 5); chk("R3 clr on match", ref_out, 1'b0);
  endtask

  task automatic t_toggle();
    drive(3'd4, 0, 4);
    drive(3'd3, 4, 4); chk("R4 toggle up", ref_out, 1'b1);
    drive(3'd3, 4, 4); chk("R4 toggle down", ref_out, 1'b0);
    drive(3'd3, 4, 4); chk("R4 toggle up again", ref_out, 1'b1);
    drive(3'd3, 1, 4); chk("R4 no match hold", ref_out, 1'b1);
  endtask

  task automatic t_pwm();
    for (int d = 0; d < 2; d++) begin
      cnt_down = logic'(d);
      for (int c = 0; c < 10; c++) begin
        logic e0;
        e0 = d ? (c <= 5) : (c < 5);
        drive(3'd6, c, 5); chk("R6 pwm0", ref_out, e0);
        drive(3'd7, c, 5); chk("R7 pwm1", ref_out, ~e0);
      end
    end
    cnt_down = 1'b0;
  endtask

  task automatic t_edges();
    for (int d = 0; d < 2; d++) begin
      cnt_down = logic'(d);
      for (int c = 0; c < 4; c++) begin
        drive(3'd6, c, 0); chk("R8 cmp0 pwm0", ref_out, 1'b0);
        drive(3'd7, c, 0); chk("R8 cmp0 pwm1", ref_out, 1'b1);
        drive(3'd6, c, 200); chk("R8 big cmp pwm0", ref_out, 1'b1);
      end
    end
    cnt_down = 1'b0;
  endtask

  task automatic t_clear();
    drive(3'd5, 1, 8);
    clr_en = 1'b0; ext_clr = 1'b1; cyc();
    chk("R9 ignored without enable", ref_out, 1'b1);
    clr_en = 1'b1; cyc();
    chk("R9 cleared", ref_out, 1'b0);
    ext_clr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cnt_val = 16'd8; cyc(); chk("R10 held through match", ref_out, 1'b0);
    end
    upd_evt = 1'b1; ext_clr = 1'b1; cyc();
    chk("R10 no release while clear high", ref_out, 1'b0);
    ext_clr = 1'b0; cyc(); upd_evt = 1'b0;
    chk("R10 released on update", ref_out, 1'b1);
    cyc(); chk("R10 stays active", ref_out, 1'b1);
    clr_en = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rst_n = 1'b1;
        t_reset();
        t_forced();
        t_freeze();
        t_setclr();
        t_toggle();
        t_pwm();
        t_edges();
        t_clear();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule